// File: doc/BRIEF.md
# Drift-Corrected Schedule Delta Tick Generator

This block paces a time-aware gate scheduler. It emits a one-cycle delta strobe every nominal 25 ticks of the local oscillator, where one tick is 8 ns and one delta is 200 ns. The same oscillator drives a PTP time counter. A servo outside this block can speed that counter up or slow it down. The generator keeps the scheduler's notion of time locked to that rate-corrected PTP time. It does this by stretching or shrinking individual deltas by whole ticks.

The generator is armed and then waits until the PTP time reaches a programmed start time. After that it paces deltas continuously. The correction period is counted in PTP time from the start time. At the first delta end on or after each period boundary, the generator measures how far PTP time has moved away from the scheduler's time. Scheduler time is counted as 25 nominal ticks per completed delta. The measured difference becomes the pending error. Each following delta removes up to 5 ticks of that error, so the correction is spread over several deltas and stays within 5 ticks per 20.

Only rate changes are tracked. When the clock is stepped, the generator must halt. It can be restarted only after it has been disarmed.

Top module: `sched_delta_gen`

## Requirements
- R1: After reset, `delta_strobe_o`, `running_o` and `aligned_o` are 0 and `phase_err_o` is 0.
- R2: `running_o` rises in the cycle after a clock edge that samples `arm_i`=1, `step_det_i`=0 and `ptp_time_i` >= `start_time_i` (unsigned). No strobe appears before that. While `arm_i` is 0, the block never starts, even once the PTP time has passed the start time.
- R3: The first delta after a start is 25 cycles long, so the strobe is high in the 25th cycle of running. `phase_err_o` is cleared to 0 at each start.
- R4: Correction boundaries lie at k × `corr_period_i` PTP ticks after `start_time_i`, for k = 1, 2, and so on. At the end of a delta where the PTP time relative to the start has reached the next boundary, the pending error is replaced by that relative PTP time minus 25 × (the number of deltas completed, counting this one). The boundary then advances by one period. A positive error means PTP time is ahead of the scheduler.
- R5: Each new delta lasts 25 − a cycles. Here a is the pending error clamped to the range −5..+5. The pending error then drops by a. `phase_err_o` changes only in the cycle right after a strobe, or at a start.
- R6: The spacing between consecutive strobes, and from the start to the first strobe, is always between 20 and 30 cycles.
- R7: A measured error outside the signed `ERR_W`-bit range saturates to the nearest limit before the per-delta clamp is applied.
- R8: When `step_det_i` is high at a clock edge, `running_o` is 0 from the next cycle on and no strobes are produced. A new start requires `arm_i` to be 0 for at least one edge, and then the start condition of R2 to hold again.
- R9: `aligned_o` is 1 exactly when the block is running and the pending error is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Permits a start; drop to 0 to leave the halted state |
| step_det_i | input | 1 | PTP time was stepped; halts the generator |
| ptp_time_i | input | TIME_W | Rate-corrected PTP time in 8 ns ticks |
| start_time_i | input | TIME_W | PTP time at which pacing begins |
| corr_period_i | input | TIME_W | Correction period in PTP ticks |
| delta_strobe_o | output | 1 | High for the last cycle of each delta |
| phase_err_o | output | ERR_W | Signed pending error in ticks |
| aligned_o | output | 1 | Running with no pending error |
| running_o | output | 1 | Generator is pacing deltas |

## Verification
The bench builds the block with a 32-bit time and an 8-bit error, keeping the nominal 25-tick delta and the 5-tick step. The narrow error width lets a single 200-tick jump in PTP time drive the measurement into saturation. Short correction periods of 50 and 100 ticks put several boundaries, and the way a residual error is worked off across deltas, inside a few hundred cycles. A long random run, where PTP time sometimes skips or doubles a tick, checks the strobe spacing. Its settling tail then checks that the generator returns to the aligned state.

// File: rtl/sdg_pkg.sv
`timescale 1ns/1ps
package sdg_pkg;
  typedef enum logic [1:0] {
    SDG_IDLE = 2'd0,
    SDG_RUN  = 2'd1,
    SDG_HALT = 2'd2
  } sdg_state_e;
endpackage

// File: rtl/sdg_launch_fsm.sv
`timescale 1ns/1ps
module sdg_launch_fsm #(
  parameter int TIME_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              step_i,
  input  logic [TIME_W-1:0] ptp_time_i,
  input  logic [TIME_W-1:0] start_time_i,
  output logic              go_o,
  output logic              run_o
);
  import sdg_pkg::*;

  sdg_state_e state_q, state_d;
  logic       start_reached;

  assign start_reached = (ptp_time_i >= start_time_i);

  always_comb begin
    state_d = state_q;
    go_o    = 1'b0;
    case (state_q)
      SDG_IDLE: begin
        if (arm_i && !step_i && start_reached) begin
          go_o    = 1'b1;
          state_d = SDG_RUN;
        end
      end
      SDG_RUN: begin
        if (step_i) begin
          state_d = SDG_HALT;
        end else if (!arm_i) begin
          state_d = SDG_IDLE;
        end
      end
      SDG_HALT: begin
        if (!arm_i) begin
          state_d = SDG_IDLE;
        end
      end
      default: state_d = SDG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SDG_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign run_o = (state_q == SDG_RUN);
endmodule

// File: rtl/sdg_drift_tracker.sv
`timescale 1ns/1ps
module sdg_drift_tracker #(
  parameter int TIME_W  = 48,
  parameter int ERR_W   = 16,
  parameter int MAX_ADJ = 5,
  parameter int ADJ_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go_i,
  input  logic                    run_i,
  input  logic                    strobe_i,
  input  logic [TIME_W-1:0]       ptp_time_i,
  input  logic [TIME_W-1:0]       start_time_i,
  input  logic [TIME_W-1:0]       period_i,
  input  logic [TIME_W-1:0]       sched_end_i,
  output logic signed [ADJ_W-1:0] adj_o,
  output logic signed [ERR_W-1:0] err_o
);
  localparam logic signed [TIME_W:0]  MEAS_HI = (TIME_W+1)'((2 ** (ERR_W - 1)) - 1);
  localparam logic signed [TIME_W:0]  MEAS_LO = -MEAS_HI - 1;
  localparam logic signed [ERR_W-1:0] ERR_LIM = ERR_W'(MAX_ADJ);
  localparam logic signed [ADJ_W-1:0] ADJ_LIM = ADJ_W'(MAX_ADJ);

  logic [TIME_W-1:0]       ptp_rel;
  logic [TIME_W-1:0]       bound_q, bound_d;
  logic                    boundary_hit;
  logic signed [TIME_W:0]  meas_wide;
  logic signed [ERR_W-1:0] meas_sat;
  logic signed [ERR_W-1:0] err_q, err_d, err_sel, adj_ext;
  logic signed [ADJ_W-1:0] adj;
  logic                    upd_en;

  assign ptp_rel      = ptp_time_i - start_time_i;
  assign boundary_hit = (ptp_rel >= bound_q);
  assign meas_wide    = $signed({1'b0, ptp_rel}) - $signed({1'b0, sched_end_i});

  always_comb begin
    if (meas_wide > MEAS_HI) begin
      meas_sat = MEAS_HI[ERR_W-1:0];
    end else if (meas_wide < MEAS_LO) begin
      meas_sat = MEAS_LO[ERR_W-1:0];
    end else begin
      meas_sat = meas_wide[ERR_W-1:0];
    end
  end

  assign err_sel = (strobe_i && boundary_hit) ? meas_sat : err_q;

  always_comb begin
    if (err_sel > ERR_LIM) begin
      adj = ADJ_LIM;
    end else if (err_sel < -ERR_LIM) begin
      adj = -ADJ_LIM;
    end else begin
      adj = err_sel[ADJ_W-1:0];
    end
  end

  assign adj_ext = {{(ERR_W-ADJ_W){adj[ADJ_W-1]}}, adj};
  assign upd_en  = go_i || (run_i && strobe_i);

  always_comb begin
    err_d   = err_q;
    bound_d = bound_q;
    if (go_i) begin
      err_d   = '0;
      bound_d = period_i;
    end else if (run_i && strobe_i) begin
      err_d = err_sel - adj_ext;
      if (boundary_hit) begin
        bound_d = bound_q + period_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= '0;
      bound_q <= '0;
    end else if (upd_en) begin
      err_q   <= err_d;
      bound_q <= bound_d;
    end
  end

  assign adj_o = adj;
  assign err_o = err_q;
endmodule

// File: rtl/sdg_delta_shaper.sv
`timescale 1ns/1ps
module sdg_delta_shaper #(
  parameter int TIME_W    = 48,
  parameter int NOM_TICKS = 25,
  parameter int LEN_W     = 5,
  parameter int ADJ_W     = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go_i,
  input  logic                    run_i,
  input  logic signed [ADJ_W-1:0] adj_i,
  output logic                    strobe_o,
  output logic [TIME_W-1:0]       sched_end_o
);
  localparam logic [LEN_W-1:0]  NOM_LEN  = LEN_W'(NOM_TICKS);
  localparam logic [TIME_W-1:0] NOM_TIME = TIME_W'(NOM_TICKS);

  logic [LEN_W-1:0]       cnt_q, cnt_d, len_q, len_d;
  logic [TIME_W-1:0]      base_q, base_d;
  logic                   last_tick;
  logic signed [LEN_W:0]  len_calc;
  logic                   cnt_en;

  assign last_tick   = (cnt_q == (len_q - 1'b1));
  assign strobe_o    = run_i && last_tick;
  assign sched_end_o = base_q + NOM_TIME;
  assign len_calc    = $signed({1'b0, NOM_LEN}) - {{(LEN_W+1-ADJ_W){adj_i[ADJ_W-1]}}, adj_i};
  assign cnt_en      = go_i || run_i;

  always_comb begin
    cnt_d  = cnt_q;
    len_d  = len_q;
    base_d = base_q;
    if (go_i) begin
      cnt_d  = '0;
      len_d  = NOM_LEN;
      base_d = '0;
    end else if (last_tick) begin
      cnt_d  = '0;
      len_d  = len_calc[LEN_W-1:0];
      base_d = base_q + NOM_TIME;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      len_q  <= NOM_LEN;
      base_q <= '0;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      base_q <= base_d;
    end
  end
endmodule

// File: rtl/sched_delta_gen.sv
`timescale 1ns/1ps
module sched_delta_gen #(
  parameter int TIME_W    = 48,
  parameter int ERR_W     = 16,
  parameter int NOM_TICKS = 25,
  parameter int MAX_ADJ   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              step_det_i,
  input  logic [TIME_W-1:0] ptp_time_i,
  input  logic [TIME_W-1:0] start_time_i,
  input  logic [TIME_W-1:0] corr_period_i,
  output logic              delta_strobe_o,
  output logic [ERR_W-1:0]  phase_err_o,
  output logic              aligned_o,
  output logic              running_o
);
  localparam int LEN_W = $clog2(NOM_TICKS + MAX_ADJ + 1);
  localparam int ADJ_W = $clog2(MAX_ADJ + 1) + 1;

  logic [1:0]              rst_pipe_q;
  logic                    rst_n_int;
  logic                    go, run, strobe;
  logic [TIME_W-1:0]       sched_end;
  logic signed [ADJ_W-1:0] adj;
  logic signed [ERR_W-1:0] err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  sdg_launch_fsm #(.TIME_W(TIME_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .arm_i        (arm_i),
    .step_i       (step_det_i),
    .ptp_time_i   (ptp_time_i),
    .start_time_i (start_time_i),
    .go_o         (go),
    .run_o        (run)
  );

  sdg_delta_shaper #(
    .TIME_W(TIME_W), .NOM_TICKS(NOM_TICKS), .LEN_W(LEN_W), .ADJ_W(ADJ_W)
  ) u_shaper (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .go_i        (go),
    .run_i       (run),
    .adj_i       (adj),
    .strobe_o    (strobe),
    .sched_end_o (sched_end)
  );

  sdg_drift_tracker #(
    .TIME_W(TIME_W), .ERR_W(ERR_W), .MAX_ADJ(MAX_ADJ), .ADJ_W(ADJ_W)
  ) u_tracker (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .go_i         (go),
    .run_i        (run),
    .strobe_i     (strobe),
    .ptp_time_i   (ptp_time_i),
    .start_time_i (start_time_i),
    .period_i     (corr_period_i),
    .sched_end_i  (sched_end),
    .adj_o        (adj),
    .err_o        (err)
  );

  assign delta_strobe_o = strobe;
  assign running_o      = run;
  assign phase_err_o    = err;
  assign aligned_o      = run && (err == '0);
endmodule

// File: rtl/sdg_checker.sv
`timescale 1ns/1ps
module sdg_checker #(
  parameter int TIME_W    = 48,
  parameter int ERR_W     = 16,
  parameter int NOM_TICKS = 25,
  parameter int MAX_ADJ   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm_i,
  input logic              step_det_i,
  input logic [TIME_W-1:0] ptp_time_i,
  input logic [TIME_W-1:0] start_time_i,
  input logic              delta_strobe_o,
  input logic [ERR_W-1:0]  phase_err_o,
  input logic              running_o
);
  logic [7:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (!running_o || delta_strobe_o) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + 8'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |-> !delta_strobe_o); // R8

  AST_LAUNCH_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_o) |-> ($past(arm_i) && ($past(ptp_time_i) >= $past(start_time_i)))); // R2

  AST_STEP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    step_det_i |=> !running_o); // R8

  AST_DELTA_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    delta_strobe_o |-> ((int'(gap_q) + 1 >= NOM_TICKS - MAX_ADJ) &&
                        (int'(gap_q) + 1 <= NOM_TICKS + MAX_ADJ))); // R6

  AST_ERR_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && $past(running_o) && !$stable(phase_err_o)) |-> $past(delta_strobe_o)); // R5
endmodule

bind sched_delta_gen sdg_checker #(
  .TIME_W(TIME_W), .ERR_W(ERR_W), .NOM_TICKS(NOM_TICKS), .MAX_ADJ(MAX_ADJ)
) u_sdg_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .arm_i          (arm_i),
  .step_det_i     (step_det_i),
  .ptp_time_i     (ptp_time_i),
  .start_time_i   (start_time_i),
  .delta_strobe_o (delta_strobe_o),
  .phase_err_o    (phase_err_o),
  .running_o      (running_o)
);

// File: tb/tb_sched_delta_gen.sv
`timescale 1ns/1ps
module tb_sched_delta_gen;
  localparam int TW = 32;
  localparam int EW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          arm, step;
  logic [TW-1:0] ptp, start, period;
  logic          strobe, aligned, running;
  logic [EW-1:0] perr;

  logic          s_strobe, s_aligned, s_running;
  int            s_err;
  int            total = 0;
  int            bad = 0;
  bit            finished = 0;

  always #2.5 clk = ~clk;

  sched_delta_gen #(.TIME_W(TW), .ERR_W(EW), .NOM_TICKS(25), .MAX_ADJ(5)) dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .step_det_i(step),
    .ptp_time_i(ptp), .start_time_i(start), .corr_period_i(period),
    .delta_strobe_o(strobe), .phase_err_o(perr), .aligned_o(aligned),
    .running_o(running)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int inc);
    @(negedge clk);
    s_strobe  = strobe;
    s_aligned = aligned;
    s_running = running;
    s_err     = int'($signed(perr));
    ptp       = ptp + TW'(inc);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    arm = 1'b0; step = 1'b0;
    repeat (3) cyc(1);
    rst_n = 1'b1;
    repeat (4) cyc(1);
  endtask

  task automatic run_to_start(input string req);
    bit early;
    early = 0;
    while (ptp != start) begin
      cyc(1);
      if (s_strobe || s_running) early = 1;
    end
    chk(!early, req, int'(early), 0);
  endtask

  function automatic bit in_list(input int n);
    int exp_n[6] = '{24, 49, 69, 89, 112, 137};
    for (int i = 0; i < 6; i++) if (exp_n[i] == n) return 1;
    return 0;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int nstrobe, last, prev_err;
    bit prev_strobe, quiet;
    void'($urandom(32'h5eed));
    ptp = 900; start = 1000; period = 50;
    do_reset();
    // R1 reset state
    chk(s_strobe == 0, "R1 strobe", int'(s_strobe), 0);
    chk(s_running == 0, "R1 running", int'(s_running), 0);
    chk(s_aligned == 0, "R1 aligned", int'(s_aligned), 0);
    chk(s_err == 0, "R1 phase_err", s_err, 0);

    // R2: no start while disarmed, even past start time
    start = 960;
    quiet = 1;
    repeat (80) begin
      cyc(1);
      if (s_running || s_strobe) quiet = 0;
    end
    chk(quiet, "R2 disarmed stays idle", int'(quiet), 1);

    // Scenario A: single 12-tick lead, period 50
    start = ptp + 30;
    arm = 1'b1;
    run_to_start("R2 no strobe before start");
    nstrobe = 0;
    for (int n = 0; n <= 150; n++) begin
      cyc(n == 3 ? 13 : 1);
      if (n == 0) begin
        chk(s_running == 1, "R2 running after start", int'(s_running), 1);
        chk(s_err == 0, "R3 error cleared", s_err, 0);
      end
      if (s_strobe) begin
        nstrobe++;
        chk(in_list(n), "R3/R5 strobe position", n, -1);
      end
      if (n == 48) chk(s_aligned == 1, "R9 aligned before boundary", int'(s_aligned), 1);
      if (n == 50) begin
        chk(s_err == 7, "R4 measured lead minus first step", s_err, 7);
        chk(s_aligned == 0, "R9 not aligned with error", int'(s_aligned), 0);
      end
      if (n == 70) chk(s_err == 2, "R5 second step of correction", s_err, 2);
      if (n == 90) begin
        chk(s_err == 0, "R4 remeasured at boundary", s_err, 0);
        chk(s_aligned == 1, "R9 aligned again", int'(s_aligned), 1);
      end
    end
    chk(nstrobe == 6, "R3/R5 strobe count", nstrobe, 6);

    // R8: step halts, stays halted while armed, restart after disarm
    step = 1'b1;
    cyc(1);
    step = 1'b0;
    chk(s_running == 0, "R8 halted after step", int'(s_running), 0);
    quiet = 1;
    repeat (60) begin
      cyc(1);
      if (s_running || s_strobe) quiet = 0;
    end
    chk(quiet, "R8 no pacing while halted", int'(quiet), 1);
    arm = 1'b0;
    cyc(1);
    start = ptp + 40;
    arm = 1'b1;
    run_to_start("R8 no early restart");
    for (int n = 0; n <= 30; n++) begin
      cyc(1);
      if (n == 0) begin
        chk(s_running == 1, "R8 restart", int'(s_running), 1);
        chk(s_err == 0, "R3 error cleared on restart", s_err, 0);
      end
      if (n == 23 || n == 24) chk(s_strobe == (n == 24), "R3 first delta after restart", int'(s_strobe), int'(n == 24));
    end

    // Scenario B: saturation of a 200-tick lead with 8-bit error
    ptp = 500; start = 520; period = 50;
    do_reset();
    arm = 1'b1;
    run_to_start("R2 no strobe before start");
    for (int n = 0; n <= 26; n++) begin
      cyc(n == 3 ? 201 : 1);
      if (n == 24) chk(s_strobe == 1 && s_err == 0, "R7 before measure", s_err, 0);
      if (n == 25) chk(s_err == 122, "R7 saturated then stepped", s_err, 122);
    end

    // Scenario C: random rate wobble, period 100
    ptp = 2000; start = 2050; period = 100;
    do_reset();
    arm = 1'b1;
    run_to_start("R2 no strobe before start");
    last = -1; prev_err = 0; prev_strobe = 0;
    for (int n = 0; n < 4000; n++) begin
      int r, inc;
      r = int'($urandom % 40);
      inc = (n >= 3000) ? 1 : (r == 0 ? 2 : (r == 1 ? 0 : 1));
      cyc(inc);
      if (s_strobe) begin
        chk((n - last) >= 20 && (n - last) <= 30, "R6 strobe spacing", n - last, 25);
        last = n;
      end
      if (n > 0 && s_err != prev_err)
        chk(prev_strobe, "R5 error moves only after strobe", s_err, prev_err);
      prev_err = s_err;
      prev_strobe = s_strobe;
    end
    chk(s_err == 0, "R4 settled error", s_err, 0);
    chk(s_aligned == 1, "R9 settled aligned", int'(s_aligned), 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule